// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block deserializes an asynchronous serial line into words of 8 or 9 data bits and holds them in a two-word buffer that a host drains with a read strobe. A free-running oversampling tick, 16 per bit period by default, paces the receiver. It finds a start bit by a falling edge that is still low at mid-bit. It takes each data bit and the stop bit by a three-sample majority vote near the bit centre. Data arrives least significant bit first.

In 9-bit mode the last received bit is reported beside the buffered byte. When the address filter is on, only frames whose ninth bit is 1 reach the buffer. This lets a node on a shared multi-drop line ignore data frames meant for others. A stop bit sampled low marks the word with a framing flag that travels with it through the buffer. A frame that completes while the buffer is full raises a sticky overrun flag. Turning the receiver off is the only way to clear that flag. A master port enable clears and holds all receive logic while it is low. The `data_avail` output stays high as long as any word is buffered, and serves as the interrupt level.

Top module: `uart9_rx`

## Requirements
- R1: While `port_en` is 0 the buffer is flushed and held empty, `overrun_err` is 0, and frames on the line are not received.
- R2: While `rx_enable` is 0 no frame is received; buffered words are kept.
- R3: With `nine_bit_mode` = 0 a frame is a start bit, 8 data bits sent least significant bit first, and a stop bit. `rd_word` shows the byte and `rd_bit9` reads 0.
- R4: With `nine_bit_mode` = 1 a frame carries 9 data bits, least significant bit first. The ninth bit appears on `rd_bit9` with no parity check.
- R5: With `nine_bit_mode` = 1 and `addr_filter_en` = 1, a frame whose ninth bit is 0 is discarded with no change to the buffer, and one whose ninth bit is 1 is loaded.
- R6: With `nine_bit_mode` = 0 the setting of `addr_filter_en` has no effect; every frame is loaded.
- R7: `frame_err` is 1 when the oldest buffered word was received with its stop bit sampled low. It is 0 for a good word and 0 while the buffer is empty.
- R8: The buffer holds two words in arrival order. A one-cycle `rd_pop` removes the oldest word, and a pop on an empty buffer is ignored. `data_avail` is 1 exactly while at least one word is held.
- R9: A frame that completes while both words are held, with no pop in that cycle, sets `overrun_err` and is lost. While `overrun_err` is 1 no frame is loaded, and reads do not clear it.
- R10: Writing `rx_enable` to 0 clears `overrun_err`.
- R11: If a frame completes in the same cycle that `rd_pop` removes a word from a full buffer, the oldest word leaves, the new word enters, and `overrun_err` stays 0.
- R12: After reset `data_avail`, `frame_err`, `overrun_err`, `rd_word` and `rd_bit9` are all 0.
- R13: A low pulse on the idle line that is gone before mid-bit does not start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Master enable; 0 clears and holds the receiver |
| nine_bit_mode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| rx_enable | input | 1 | Receiver on; 0 also clears overrun |
| addr_filter_en | input | 1 | In 9-bit mode, load only frames with ninth bit 1 |
| baud_tick | input | 1 | One oversampling tick (OSR per bit period) |
| rx_line | input | 1 | Serial input, idle high |
| rd_pop | input | 1 | Remove the oldest buffered word |
| rd_word | output | DATA_W | Oldest buffered byte, 0 when empty |
| rd_bit9 | output | 1 | Ninth bit of the oldest word |
| frame_err | output | 1 | Stop-bit error of the oldest word |
| overrun_err | output | 1 | Sticky overrun flag |
| data_avail | output | 1 | Buffer holds at least one word (interrupt level) |

## Verification
The cycle in which a frame completes can coincide with a host pop. On a full buffer this decides between a clean exchange of words and an overrun. The bench drives the tick on every clock, so it can count the exact cycle in which the stop-bit decision reaches the buffer, and it raises `rd_pop` for that single cycle while the third frame arrives. It then judges the result by the flag staying 0 and by the two remaining words coming out in order. A pop one cycle late would leave the overrun flag set instead.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       bit9;
    logic       ferr;
  } rx_word_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_DATA  = 2'd2,
    S_STOP  = 2'd3
  } rx_state_t;

endpackage

// File: rtl/uart9_deser.sv
module uart9_deser
  import uart9_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     tick,
  input  logic     nine,
  input  logic     rx_in,
  output logic     done,
  output rx_word_t word
);

  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [1:0]      sync_q;
  logic            rx_s;
  rx_state_t       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d, cnt_inc;
  logic [IW-1:0]   bidx_q, bidx_d, nbits;
  logic [1:0]      hist_q, hist_d;
  logic [DATA_W:0] sh_q, sh_d;
  logic            done_q, done_d;
  rx_word_t        word_q, word_d;
  logic            vote;

  assign rx_s    = sync_q[1];
  assign vote    = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_s) | (hist_q[0] & rx_s);
  assign nbits   = nine ? IW'(DATA_W + 1) : IW'(DATA_W);
  assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bidx_d = bidx_q;
    hist_d = hist_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    word_d = word_q;
    if (clr) begin
      st_d   = S_IDLE;
      cnt_d  = '0;
      bidx_d = '0;
      hist_d = '0;
    end else if (tick) begin
      unique case (st_q)
        S_IDLE: begin
          if (!rx_s) begin
            st_d  = S_START;
            cnt_d = '0;
          end
        end
        S_START: begin
          if (cnt_q == MID) begin
            cnt_d  = '0;
            bidx_d = '0;
            st_d   = rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        S_DATA: begin
          hist_d = {hist_q[0], rx_s};
          cnt_d  = cnt_inc;
          if (cnt_q == LAST) begin
            sh_d   = {vote, sh_q[DATA_W:1]};
            bidx_d = bidx_q + 1'b1;
            if (bidx_q == nbits - 1'b1) st_d = S_STOP;
          end
        end
        S_STOP: begin
          hist_d = {hist_q[0], rx_s};
          cnt_d  = cnt_inc;
          if (cnt_q == LAST) begin
            st_d        = S_IDLE;
            done_d      = 1'b1;
            word_d.ferr = !vote;
            if (nine) begin
              word_d.data = sh_q[DATA_W-1:0];
              word_d.bit9 = sh_q[DATA_W];
            end else begin
              word_d.data = sh_q[DATA_W:1];
              word_d.bit9 = 1'b0;
            end
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      hist_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      hist_q <= hist_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      word_q <= word_d;
    end
  end

  assign done = done_q;
  assign word = word_q;

  // A completed frame is reported for exactly one cycle (R8).
  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // A start that survives to mid-bit is the only way into the data phase (R13).
  assert_start_confirm_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_START && st_d == S_DATA) |-> !rx_s);

endmodule

// File: rtl/uart9_fifo.sv
module uart9_fifo
  import uart9_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     push,
  input  logic     pop,
  input  rx_word_t wdata,
  output rx_word_t rdata,
  output logic     full,
  output logic     empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [NW-1:0] NFULL = NW'(DEPTH);

  rx_word_t      mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == NFULL);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = empty ? '0 : mem_q[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_pop)  rd_d = (rd_q == PLAST) ? '0 : rd_q + 1'b1;
      if (do_push) wr_d = (wr_q == PLAST) ? '0 : wr_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && !flush && wr_q == PW'(i)) mem_q[i] <= wdata;
    end
  end

  // The owner never offers a word that would be lost on a full buffer (R11).
  assert_no_lost_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              nine_bit_mode,
  input  logic              rx_enable,
  input  logic              addr_filter_en,
  input  logic              baud_tick,
  input  logic              rx_line,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_bit9,
  output logic              frame_err,
  output logic              overrun_err,
  output logic              data_avail
);

  logic     rx_off;
  logic     fr_done;
  rx_word_t fr_word;
  rx_word_t head;
  logic     buf_full, buf_empty;
  logic     filter_drop, accept, buf_push;
  logic     ovr_q, ovr_d;

  assign rx_off = !port_en || !rx_enable;

  uart9_deser #(
    .OSR   (OSR),
    .DATA_W(DATA_W)
  ) u_deser (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (rx_off),
    .tick (baud_tick),
    .nine (nine_bit_mode),
    .rx_in(rx_line),
    .done (fr_done),
    .word (fr_word)
  );

  assign filter_drop = nine_bit_mode && addr_filter_en && !fr_word.bit9;
  assign accept      = fr_done && !filter_drop && !rx_off;
  assign buf_push    = accept && !ovr_q && (!buf_full || rd_pop);

  always_comb begin
    ovr_d = ovr_q;
    if (rx_off)                                  ovr_d = 1'b0;
    else if (accept && buf_full && !rd_pop)      ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  uart9_fifo #(
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(!port_en),
    .push (buf_push),
    .pop  (rd_pop),
    .wdata(fr_word),
    .rdata(head),
    .full (buf_full),
    .empty(buf_empty)
  );

  assign rd_word     = head.data;
  assign rd_bit9     = head.bit9;
  assign frame_err   = head.ferr;
  assign overrun_err = ovr_q;
  assign data_avail  = !buf_empty;

  assert_disabled_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!data_avail && !overrun_err));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_err && rx_enable && port_en) |=> overrun_err);

  assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !overrun_err);

  assert_filter_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && port_en && nine_bit_mode && addr_filter_en && !fr_word.bit9 && !rd_pop)
      |=> $stable(data_avail));

  assert_empty_no_ferr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> !frame_err);

endmodule

// File: tb/uart9_rx_tb.sv
module uart9_rx_tb_top;

  logic       clk;
  logic       rst_n;
  logic       port_en, nine_bit_mode, rx_enable, addr_filter_en;
  logic       baud_tick, rx_line, rd_pop;
  logic [7:0] rd_word;
  logic       rd_bit9, frame_err, overrun_err, data_avail;

  int total;
  int fails;
  bit finished;

  uart9_rx dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_en       (port_en),
    .nine_bit_mode (nine_bit_mode),
    .rx_enable     (rx_enable),
    .addr_filter_en(addr_filter_en),
    .baud_tick     (baud_tick),
    .rx_line       (rx_line),
    .rd_pop        (rd_pop),
    .rd_word       (rd_word),
    .rd_bit9       (rd_bit9),
    .frame_err     (frame_err),
    .overrun_err   (overrun_err),
    .data_avail    (data_avail)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {nine, filter, data[8:0], stop, expect_loaded, expect_ferr}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 9'h0A5, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 9'h13C, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 9'h15A, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 9'h0C3, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 9'h077, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 9'h1E1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 9'h081, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 9'h1FF, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b1, 9'h000, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input logic nine, input logic stop_v);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i]);
    drive_bit(stop_v);
    rx_line = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  function automatic string vec_tag(input logic [13:0] v);
    if (!v[1])      return "R5";
    else if (v[0])  return "R7";
    else if (v[13]) return (v[12] ? "R5" : "R4");
    else if (v[12]) return "R6";
    else            return "R3";
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    total = 0;
    fails = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    port_en = 1'b0;
    nine_bit_mode = 1'b0;
    rx_enable = 1'b0;
    addr_filter_en = 1'b0;
    baud_tick = 1'b1;
    rx_line = 1'b1;
    rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset values
    chk("R12 avail", data_avail, 0);
    chk("R12 ferr", frame_err, 0);
    chk("R12 ovr", overrun_err, 0);
    chk("R12 word", rd_word, 0);
    chk("R12 bit9", rd_bit9, 0);

    // R1: port disabled ignores the line
    rx_enable = 1'b1;
    send_frame(9'h055, 1'b0, 1'b1);
    chk("R1 ignored", data_avail, 0);

    // R2: receiver off ignores the line
    port_en = 1'b1;
    rx_enable = 1'b0;
    send_frame(9'h066, 1'b0, 1'b1);
    chk("R2 ignored", data_avail, 0);
    rx_enable = 1'b1;

    // R13: short glitch does not start a frame
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    chk("R13 glitch", data_avail, 0);

    // Vector table: R3..R7
    for (int k = 0; k < NV; k++) begin
      logic [13:0] v;
      v = VEC[k];
      nine_bit_mode = v[13];
      addr_filter_en = v[12];
      send_frame(v[11:3], v[13], v[2]);
      chk(vec_tag(v), data_avail, v[1]);
      if (v[1]) begin
        chk(vec_tag(v), rd_word, v[10:3]);
        chk(vec_tag(v), rd_bit9, v[13] ? v[11] : 1'b0);
        chk("R7", frame_err, v[0]);
        pop_one();
      end
      chk("R8 drained", data_avail, 0);
      chk("R7 empty", frame_err, 0);
    end
    nine_bit_mode = 1'b0;
    addr_filter_en = 1'b0;

    // R8: order, pop on empty ignored
    send_frame(9'h011, 1'b0, 1'b1);
    send_frame(9'h022, 1'b0, 1'b0);
    chk("R8 first", rd_word, 8'h11);
    chk("R7 first good", frame_err, 0);
    pop_one();
    chk("R8 second", rd_word, 8'h22);
    chk("R7 second bad", frame_err, 1);
    pop_one();
    chk("R8 empty", data_avail, 0);
    pop_one();
    send_frame(9'h033, 1'b0, 1'b1);
    chk("R8 after empty pop", rd_word, 8'h33);
    pop_one();

    // R9: overrun
    send_frame(9'h041, 1'b0, 1'b1);
    send_frame(9'h042, 1'b0, 1'b1);
    chk("R9 no ovr yet", overrun_err, 0);
    send_frame(9'h043, 1'b0, 1'b1);
    chk("R9 ovr set", overrun_err, 1);
    chk("R9 head kept", rd_word, 8'h41);
    pop_one();
    chk("R9 second kept", rd_word, 8'h42);
    pop_one();
    chk("R9 third lost", data_avail, 0);
    send_frame(9'h044, 1'b0, 1'b1);
    chk("R9 blocked", data_avail, 0);
    chk("R9 sticky", overrun_err, 1);

    // R10: clear by disabling receiver
    @(negedge clk);
    rx_enable = 1'b0;
    @(negedge clk);
    chk("R10 cleared", overrun_err, 0);
    rx_enable = 1'b1;
    send_frame(9'h045, 1'b0, 1'b1);
    chk("R10 loads again", rd_word, 8'h45);

    // R1: disabling port flushes buffer
    @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    chk("R1 flushed", data_avail, 0);
    port_en = 1'b1;

    // R11: pop coincides with frame completion on full buffer
    send_frame(9'h0A1, 1'b0, 1'b1);
    send_frame(9'h0A2, 1'b0, 1'b1);
    fork
      send_frame(9'h0A3, 1'b0, 1'b1);
      begin
        @(negedge clk);
        repeat (155) @(posedge clk);
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
      end
    join
    chk("R11 no ovr", overrun_err, 0);
    chk("R11 head", rd_word, 8'hA2);
    pop_one();
    chk("R11 new word", rd_word, 8'hA3);
    pop_one();
    chk("R11 empty", data_avail, 0);

    finish_run();
  end

endmodule